// File: doc/BRIEF.md
# ADC Result Limit Comparator

This unit sits between an analog-to-digital conversion engine and the register that software reads. When a conversion finishes, the engine pulses a valid strobe together with the new sample. If limit checking is enabled, the unit tests the sample against a programmed threshold, either as a ceiling test or as a floor test. It updates the visible result and raises the done flag only when the sample meets the test. The stored value is then the sample plus the bitwise inverse of the threshold, taken at the active resolution, not the sample itself. If limit checking is disabled, every conversion stores the raw sample and raises the flag.

Two resolutions are supported: the full parameterised width (12 bits by default) and a narrow 8-bit mode. In narrow mode, only the low byte of the sample and of the threshold take part in the test. The upper bits of any value the unit stores are zero. Reading the result clears the flag, and an interrupt output follows the flag when it is enabled.

Top module: `adc_limit_cmp`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted conversion, `result_out` is 0, `done_flag` is 0 and `irq_out` is 0.
- R2: With `cmp_en`=0, each cycle with `conv_valid`=1 loads the masked sample into `result_out` and sets `done_flag` at the next clock edge.
- R3: With `cmp_en`=1 and `cmp_upper`=1, a conversion whose sample is greater than or equal to `cmp_val` sets `done_flag` and loads (sample + ~cmp_val) modulo 2^width.
- R4: With `cmp_en`=1 and `cmp_upper`=0, a conversion whose sample is strictly less than `cmp_val` sets `done_flag` and loads (sample + ~cmp_val) modulo 2^width.
- R5: A compared conversion that fails its test leaves `result_out` and `done_flag` unchanged.
- R6: A cycle with `result_rd`=1 and no accepted conversion clears `done_flag` at the next edge and leaves `result_out` unchanged.
- R7: When an accepted conversion and `result_rd` fall in the same cycle, `done_flag` is 1 after the edge.
- R8: With `res_low8`=1, only bits [7:0] of the sample and of `cmp_val` are used. The test is made at 8 bits, and bits [11:8] of any value loaded are 0.
- R9: `irq_out` equals `done_flag` AND `irq_en` in the same cycle.
- R10: In cycles with `conv_valid`=0, changes on `conv_data`, `cmp_val` or the mode inputs do not alter `result_out` or set `done_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | W (12) | Converted sample |
| cmp_val | input | W (12) | Threshold for the limit test |
| cmp_en | input | 1 | 1 = limit test active |
| cmp_upper | input | 1 | 1 = ceiling test (>=), 0 = floor test (<) |
| res_low8 | input | 1 | 1 = 8-bit resolution |
| result_rd | input | 1 | Result register is being read; clears the flag |
| irq_en | input | 1 | Interrupt enable |
| result_out | output | W (12) | Result register |
| done_flag | output | 1 | Completion flag |
| irq_out | output | 1 | Interrupt request |

## Verification
A wrong carry tap, or a mode decode that is inverted, shows up in the flag and the result one edge after the strobe. For that reason every table vector is checked on the cycle right after its conversion. A retention fault, such as a failing test that overwrites the register, shows up as a changed `result_out` on the same cycle. The bench follows each pass vector with a fail vector so that this is seen. A clear/set ordering fault only shows when the read and the strobe coincide, so that case is driven as its own test.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic {
        LIMIT_BELOW = 1'b0,
        LIMIT_ABOVE = 1'b1
    } limit_mode_e;

    typedef enum logic {
        RES_FULL = 1'b0,
        RES_LOW8 = 1'b1
    } res_mode_e;

endpackage

// File: rtl/alc_operand_mask.sv
module alc_operand_mask #(
    parameter int W        = 12,
    parameter int NARROW_W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] thr_i,
    input  logic         narrow_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] thr_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_low
            assign data_o[i] = data_i[i];
            assign thr_o[i]  = thr_i[i];
        end else begin : g_high
            assign data_o[i] = data_i[i] & ~narrow_i;
            assign thr_o[i]  = thr_i[i]  & ~narrow_i;
        end
    end
endmodule

// File: rtl/alc_compare_core.sv
module alc_compare_core #(
    parameter int W        = 12,
    parameter int NARROW_W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] thr_i,
    input  logic         narrow_i,
    output logic [W-1:0] sum_o,
    output logic         at_or_above_o
);
    localparam int HI_W = W - NARROW_W;
    localparam logic [W-1:0] NARROW_MASK = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [W-1:0] FULL_MASK   = {W{1'b1}};

    logic [W-1:0] width_mask;
    logic [W-1:0] inv_thr;
    logic [W:0]   raw_sum;
    logic [W:0]   carry;

    always_comb begin
        width_mask = narrow_i ? NARROW_MASK : FULL_MASK;
        inv_thr    = ~thr_i & width_mask;
        raw_sum    = {1'b0, data_i} + {1'b0, inv_thr};
        sum_o      = raw_sum[W-1:0] & width_mask;
    end

    // Ripple chain of data + ~thr + 1; carry out means data >= thr.
    assign carry[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_carry
        assign carry[i+1] = (data_i[i] & inv_thr[i])
                          | (data_i[i] & carry[i])
                          | (inv_thr[i] & carry[i]);
    end

    assign at_or_above_o = narrow_i ? carry[NARROW_W] : carry[W];
endmodule

// File: rtl/alc_result_state.sv
module alc_result_state #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_valid_i,
    input  logic         cmp_en_i,
    input  logic         mode_upper_i,
    input  logic         at_or_above_i,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] sum_i,
    input  logic         read_i,
    output logic [W-1:0] result_o,
    output logic         flag_o
);
    import alc_pkg::*;

    typedef struct packed {
        logic [W-1:0] result;
        logic         flag;
    } state_t;

    state_t state_d, state_q;
    logic   limit_hit;
    logic   accept;

    always_comb begin
        state_d   = state_q;
        limit_hit = (limit_mode_e'(mode_upper_i) == LIMIT_ABOVE) ? at_or_above_i
                                                                 : ~at_or_above_i;
        accept    = conv_valid_i & (~cmp_en_i | limit_hit);
        if (read_i) begin
            state_d.flag = 1'b0;
        end
        if (accept) begin
            state_d.result = cmp_en_i ? sum_i : raw_i;
            state_d.flag   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign flag_o   = state_q.flag;
endmodule

// File: rtl/adc_limit_cmp.sv
module adc_limit_cmp #(
    parameter int W        = 12,
    parameter int NARROW_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_valid,
    input  logic [W-1:0] conv_data,
    input  logic [W-1:0] cmp_val,
    input  logic         cmp_en,
    input  logic         cmp_upper,
    input  logic         res_low8,
    input  logic         result_rd,
    input  logic         irq_en,
    output logic [W-1:0] result_out,
    output logic         done_flag,
    output logic         irq_out
);
    logic [W-1:0] op_data;
    logic [W-1:0] op_thr;
    logic [W-1:0] sum;
    logic         at_or_above;

    alc_operand_mask #(.W(W), .NARROW_W(NARROW_W)) u_mask (
        .data_i   (conv_data),
        .thr_i    (cmp_val),
        .narrow_i (res_low8),
        .data_o   (op_data),
        .thr_o    (op_thr)
    );

    alc_compare_core #(.W(W), .NARROW_W(NARROW_W)) u_core (
        .data_i        (op_data),
        .thr_i         (op_thr),
        .narrow_i      (res_low8),
        .sum_o         (sum),
        .at_or_above_o (at_or_above)
    );

    alc_result_state #(.W(W)) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_valid_i  (conv_valid),
        .cmp_en_i      (cmp_en),
        .mode_upper_i  (cmp_upper),
        .at_or_above_i (at_or_above),
        .raw_i         (op_data),
        .sum_i         (sum),
        .read_i        (result_rd),
        .result_o      (result_out),
        .flag_o        (done_flag)
    );

    assign irq_out = done_flag & irq_en;
endmodule

// File: rtl/adc_limit_cmp_chk.sv
module adc_limit_cmp_chk #(
    parameter int W        = 12,
    parameter int NARROW_W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_valid,
    input logic [W-1:0] conv_data,
    input logic [W-1:0] cmp_val,
    input logic         cmp_en,
    input logic         cmp_upper,
    input logic         res_low8,
    input logic         result_rd,
    input logic         irq_en,
    input logic [W-1:0] result_out,
    input logic         done_flag,
    input logic         irq_out
);
    localparam int HI_W = W - NARROW_W;
    localparam logic [W-1:0] NARROW_MASK = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [W-1:0] FULL_MASK   = {W{1'b1}};

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (result_out == '0 && !done_flag));

    a_r2_raw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !cmp_en) |=> (done_flag &&
            result_out == ($past(conv_data) & ($past(res_low8) ? NARROW_MASK : FULL_MASK))));

    a_r3_upper_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && cmp_en && cmp_upper && !res_low8 && conv_data >= cmp_val) |=> done_flag);

    a_r4_lower_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && cmp_en && !cmp_upper && !res_low8 && conv_data < cmp_val) |=> done_flag);

    a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && !conv_valid) |=> (!done_flag && $stable(result_out)));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && conv_valid && !cmp_en) |=> done_flag);

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && res_low8 && !cmp_en) |=> (result_out[W-1:NARROW_W] == '0));

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (done_flag && irq_en));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> ($stable(result_out) && !$rose(done_flag)));
endmodule

bind adc_limit_cmp adc_limit_cmp_chk #(.W(W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .cmp_val    (cmp_val),
    .cmp_en     (cmp_en),
    .cmp_upper  (cmp_upper),
    .res_low8   (res_low8),
    .result_rd  (result_rd),
    .irq_en     (irq_en),
    .result_out (result_out),
    .done_flag  (done_flag),
    .irq_out    (irq_out)
);

// File: tb/adc_limit_cmp_bench.sv
`timescale 1ns/100ps
module adc_limit_cmp_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_valid = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic [W-1:0] cmp_val = '0;
    logic         cmp_en = 1'b0;
    logic         cmp_upper = 1'b0;
    logic         res_low8 = 1'b0;
    logic         result_rd = 1'b0;
    logic         irq_en = 1'b0;
    logic [W-1:0] result_out;
    logic         done_flag;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_limit_cmp #(.W(W), .NARROW_W(8)) u_adc_limit_cmp (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
        .cmp_val(cmp_val), .cmp_en(cmp_en), .cmp_upper(cmp_upper), .res_low8(res_low8),
        .result_rd(result_rd), .irq_en(irq_en), .result_out(result_out),
        .done_flag(done_flag), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        en;
        logic        up;
        logic        low8;
        logic [11:0] data;
        logic [11:0] cv;
        logic [11:0] exp_res;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 12'h123, 12'h7AA, 12'h123, 1'b1},  // R2 raw
        '{1'b1, 1'b1, 1'b0, 12'd200, 12'd100, 12'h063, 1'b1},  // R3 above
        '{1'b1, 1'b1, 1'b0, 12'd100, 12'd100, 12'hFFF, 1'b1},  // R3 equal
        '{1'b1, 1'b1, 1'b0, 12'd99,  12'd100, 12'hFFF, 1'b0},  // R5 fail keeps
        '{1'b1, 1'b0, 1'b0, 12'd99,  12'd100, 12'hFFE, 1'b1},  // R4 below
        '{1'b1, 1'b0, 1'b0, 12'd100, 12'd100, 12'hFFE, 1'b0},  // R4/R5 equal fails
        '{1'b1, 1'b0, 1'b0, 12'h000, 12'hFFF, 12'h000, 1'b1},  // R4 extreme
        '{1'b1, 1'b1, 1'b0, 12'hFFF, 12'h000, 12'hFFE, 1'b1},  // R3 extreme
        '{1'b0, 1'b0, 1'b1, 12'hABC, 12'h000, 12'h0BC, 1'b1},  // R8 raw narrow
        '{1'b1, 1'b1, 1'b1, 12'h1F0, 12'hE10, 12'h0DF, 1'b1},  // R8 masked compare
        '{1'b1, 1'b0, 1'b1, 12'h305, 12'h006, 12'h0FE, 1'b1},  // R8 narrow below
        '{1'b1, 1'b1, 1'b1, 12'h305, 12'h006, 12'h0FE, 1'b0}   // R8/R5 narrow fail
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic convert(input logic en, input logic up, input logic low8,
                           input logic [W-1:0] d, input logic [W-1:0] cv, input logic rd);
        @(negedge clk);
        cmp_en = en; cmp_upper = up; res_low8 = low8;
        conv_data = d; cmp_val = cv; result_rd = rd; conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0; result_rd = 1'b0;
    endtask

    task automatic read_clear();
        @(negedge clk);
        result_rd = 1'b1;
        @(negedge clk);
        result_rd = 1'b0;
    endtask

    initial begin
        logic [W-1:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 result", result_out, '0);
        chk("R1 flag", {11'b0, done_flag}, 12'd0);
        chk("R1 irq", {11'b0, irq_out}, 12'd0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);
        chk("R1 after release", {done_flag, result_out[10:0]}, '0);

        for (int i = 0; i < NV; i++) begin
            convert(VEC[i].en, VEC[i].up, VEC[i].low8, VEC[i].data, VEC[i].cv, 1'b0);
            chk($sformatf("R2/R3/R4/R5/R8 vec%0d result", i), result_out, VEC[i].exp_res);
            chk($sformatf("R2/R3/R4/R5/R8 vec%0d flag", i), {11'b0, done_flag}, {11'b0, VEC[i].exp_flag});
            chk($sformatf("R9 vec%0d irq", i), {11'b0, irq_out}, {11'b0, VEC[i].exp_flag});
            held = result_out;
            read_clear();
            chk($sformatf("R6 vec%0d clear", i), {11'b0, done_flag}, 12'd0);
            chk($sformatf("R6 vec%0d keep", i), result_out, held);
        end

        // R7 set wins over same-cycle read
        convert(1'b0, 1'b0, 1'b0, 12'h5A5, 12'h000, 1'b1);
        chk("R7 flag", {11'b0, done_flag}, 12'd1);
        chk("R7 result", result_out, 12'h5A5);

        // R9 irq gating
        irq_en = 1'b0;
        #1;
        chk("R9 irq off", {11'b0, irq_out}, 12'd0);
        irq_en = 1'b1;
        #1;
        chk("R9 irq on", {11'b0, irq_out}, 12'd1);
        read_clear();

        // R10 input churn without strobe
        @(negedge clk);
        conv_data = 12'hFFF; cmp_val = 12'h001; cmp_en = 1'b0; res_low8 = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1; cmp_upper = 1'b1; conv_data = 12'h800;
        repeat (2) @(negedge clk);
        chk("R10 result", result_out, 12'h5A5);
        chk("R10 flag", {11'b0, done_flag}, 12'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule